// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This unit takes one floating-point operand in half, single or double precision and rounds it to an integral value in the same format. A 2-bit format code picks the precision. A 3-bit mode code picks the rounding: either a fixed mode, or the caller's 2-bit dynamic mode. One mode variant reports loss of precision through an inexact flag. Signaling NaNs are quieted and raise an invalid flag. Zeros, infinities and values that are already integral pass through unchanged.

The rounded lane lands in the low bits of a 128-bit result word. The bits above the lane are copied from a prior destination word when merge is enabled and are zero otherwise. Illegal format or mode codes assert an undefined indication. The result, flags and indication are registered, so they appear one clock after the inputs.

Top module: `fp_rint_unit`

## Requirements
- R1: Format code 2'b00 selects single (8-bit exponent, 23-bit fraction), 2'b01 selects double (11/52) and 2'b11 selects half (5/10) when parameter HALF_EN is 1. Code 2'b10, or 2'b11 with HALF_EN at 0, sets undef_o with result_o all zero and both flags clear.
- R2: When mode bit 2 is 0, mode bits 1:0 select the rounding: 00 nearest-even, 01 toward +infinity, 10 toward -infinity, 11 toward zero. Mode 3'b100 is nearest with ties away from zero. Modes 3'b110 and 3'b111 use dyn_rm_i, which has the same 2-bit encoding. Mode 3'b101 is undefined and gives the R1 response.
- R3: A zero or infinite operand is returned bit-for-bit, keeping its sign, and raises no flag.
- R4: A signaling NaN (top fraction bit 0) is returned with the top fraction bit set and raises invalid_o. A quiet NaN is returned unchanged with no flag. Inexact and invalid are never set together.
- R5: An operand whose unbiased exponent is at least the fraction width is returned unchanged with no flag.
- R6: Toward-zero rounding discards the fractional part, so the result magnitude never exceeds the operand magnitude.
- R7: For nearest-even, an exact half rounds to the even integer. For ties-away, an exact half rounds away from zero. A rounding carry out of the fraction increments the exponent.
- R8: A nonzero magnitude below one gives a zero with the operand's sign, or plus or minus one, according to the mode.
- R9: inexact_o is set only in mode 3'b110, and then exactly when the result differs from the finite operand.
- R10: The lane occupies result_o[15:0], [31:0] or [63:0]. With merge_i high, the bits above the lane equal dest_i; with merge_i low, they are zero.
- R11: Outputs are registered with one clock of latency. While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 64 | Operand, lane in the low bits |
| fmt_i | input | 2 | Format code |
| rmode_i | input | 3 | Rounding-mode code |
| dyn_rm_i | input | 2 | Dynamic rounding mode |
| merge_i | input | 1 | Keep upper destination bits |
| dest_i | input | 128 | Prior destination word |
| result_o | output | 128 | Rounded lane inserted into the word |
| inexact_o | output | 1 | Precision lost in exact mode |
| invalid_o | output | 1 | Signaling NaN operand |
| undef_o | output | 1 | Illegal format or mode code |

## Verification
In one cycle, the rounding carry and the lane insertion can both change the result word, and the exact-mode inexact flag can rise at the same time. For example, a single-precision 1.5 in mode 3'b110 with a nearest dynamic mode, while merge_i is high over a patterned dest_i, produces an exponent increment, the inexact flag and merged upper bits together. The bench drives such vectors on purpose and also at random across all formats and modes. It compares the full 128-bit word and both flags against its own integer model on every clock.

// File: rtl/fp_rint_pkg.sv
package fp_rint_pkg;
  typedef enum logic [2:0] {
    RM_NE = 3'd0, RM_PI = 3'd1, RM_MI = 3'd2, RM_RZ = 3'd3, RM_NA = 3'd4
  } rm_e;

  typedef enum logic [1:0] {
    FMT_S = 2'b00, FMT_D = 2'b01, FMT_BAD = 2'b10, FMT_H = 2'b11
  } fmt_e;

  // lane index: 0 half, 1 single, 2 double
  function automatic int ew_of(int g);
    return (g == 0) ? 5 : ((g == 1) ? 8 : 11);
  endfunction

  function automatic int fw_of(int g);
    return (g == 0) ? 10 : ((g == 1) ? 23 : 52);
  endfunction
endpackage

// File: rtl/fp_rint_decode.sv
module fp_rint_decode
  import fp_rint_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic [1:0] fmt_i,
  input  logic [2:0] rmode_i,
  input  logic [1:0] dyn_rm_i,
  output rm_e        rm_o,
  output logic       exact_o,
  output logic       undef_o
);
  always_comb begin
    exact_o = 1'b0;
    rm_o    = RM_NE;
    case (rmode_i)
      3'b100:         rm_o = RM_NA;
      3'b110: begin   rm_o = rm_e'({1'b0, dyn_rm_i}); exact_o = 1'b1; end
      3'b111:         rm_o = rm_e'({1'b0, dyn_rm_i});
      3'b101:         rm_o = RM_NE;
      default:        rm_o = rm_e'({1'b0, rmode_i[1:0]});
    endcase
    undef_o = (fmt_i == FMT_BAD) || ((fmt_i == FMT_H) && !HALF_EN) || (rmode_i == 3'b101);
  end
endmodule

// File: rtl/fp_rint_core.sv
module fp_rint_core
  import fp_rint_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W    = 1 + EXP_W + FRAC_W,
  localparam int MW   = EXP_W + FRAC_W,
  localparam int SH_W = $clog2(FRAC_W + 1)
) (
  input  logic [W-1:0] op_i,
  input  rm_e          rm_i,
  input  logic         exact_i,
  output logic [W-1:0] res_o,
  output logic         nx_o,
  output logic         nv_o
);
  localparam logic signed [EXP_W+1:0] BIAS = (EXP_W+2)'((1 << (EXP_W - 1)) - 1);

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic signed [EXP_W+1:0] ue;
  logic [SH_W-1:0]   sh;
  logic [MW-1:0]     mag, one_at, fmask, rem, half, rnd;
  logic              lsb, up, tiny_up, nz_rem;

  assign sgn = op_i[W-1];
  assign ex  = op_i[W-2:FRAC_W];
  assign fr  = op_i[FRAC_W-1:0];
  assign mag = op_i[W-2:0];
  assign ue  = $signed({2'b00, ex}) - BIAS;

  always_comb begin
    sh     = SH_W'(FRAC_W - int'(ue));
    one_at = MW'(1) << sh;
    fmask  = one_at - MW'(1);
    rem    = mag & fmask;
    half   = one_at >> 1;
    nz_rem = |rem;
    // integer lsb is the hidden one when the whole fraction is dropped
    lsb    = (int'(sh) == FRAC_W) ? 1'b1 : |(mag & one_at);
    case (rm_i)
      RM_NE:   up = (rem > half) || ((rem == half) && lsb);
      RM_NA:   up = (rem >= half);
      RM_PI:   up = !sgn && nz_rem;
      RM_MI:   up = sgn && nz_rem;
      default: up = 1'b0;
    endcase
    case (rm_i)
      RM_NE:   tiny_up = (ue == -1) && (fr != '0);
      RM_NA:   tiny_up = (ue == -1);
      RM_PI:   tiny_up = !sgn;
      RM_MI:   tiny_up = sgn;
      default: tiny_up = 1'b0;
    endcase
    rnd = (mag & ~fmask) + (up ? one_at : '0);

    res_o = op_i;
    nx_o  = 1'b0;
    nv_o  = 1'b0;
    if (&ex) begin
      if (fr != '0) begin
        res_o[FRAC_W-1] = 1'b1;
        nv_o = !fr[FRAC_W-1];
      end
    end else if (mag == '0) begin
      res_o = op_i;
    end else if (ue >= (EXP_W+2)'(FRAC_W)) begin
      res_o = op_i;
    end else if (ue < 0) begin
      res_o = {sgn, tiny_up ? BIAS[EXP_W-1:0] : '0, {FRAC_W{1'b0}}};
      nx_o  = exact_i;
    end else begin
      res_o = {sgn, rnd};
      nx_o  = exact_i && nz_rem;
    end
  end
endmodule

// File: rtl/fp_rint_unit.sv
module fp_rint_unit
  import fp_rint_pkg::*;
#(
  parameter bit HALF_EN = 1'b1,
  localparam int N_LANE = 3,
  localparam int WORD_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [63:0]       op_i,
  input  logic [1:0]        fmt_i,
  input  logic [2:0]        rmode_i,
  input  logic [1:0]        dyn_rm_i,
  input  logic              merge_i,
  input  logic [WORD_W-1:0] dest_i,
  output logic [WORD_W-1:0] result_o,
  output logic              inexact_o,
  output logic              invalid_o,
  output logic              undef_o
);
  rm_e  rm;
  logic exact, undef;
  logic [N_LANE-1:0] nx_w, nv_w;

  fp_rint_decode #(.HALF_EN(HALF_EN)) u_dec (
    .fmt_i, .rmode_i, .dyn_rm_i,
    .rm_o(rm), .exact_o(exact), .undef_o(undef)
  );

  for (genvar g = 0; g < N_LANE; g++) begin : gen_lane
    localparam int EW = ew_of(g);
    localparam int FW = fw_of(g);
    logic [EW+FW:0] lane_res;
    fp_rint_core #(.EXP_W(EW), .FRAC_W(FW)) u_core (
      .op_i(op_i[EW+FW:0]), .rm_i(rm), .exact_i(exact),
      .res_o(lane_res), .nx_o(nx_w[g]), .nv_o(nv_w[g])
    );
  end

  logic [WORD_W-1:0] word_d;
  logic nx_d, nv_d;

  always_comb begin
    word_d = merge_i ? dest_i : '0;
    nx_d   = 1'b0;
    nv_d   = 1'b0;
    case (fmt_i)
      FMT_H:   begin word_d[15:0] = gen_lane[0].lane_res; nx_d = nx_w[0]; nv_d = nv_w[0]; end
      FMT_S:   begin word_d[31:0] = gen_lane[1].lane_res; nx_d = nx_w[1]; nv_d = nv_w[1]; end
      FMT_D:   begin word_d[63:0] = gen_lane[2].lane_res; nx_d = nx_w[2]; nv_d = nv_w[2]; end
      default: ;
    endcase
    if (undef) begin
      word_d = '0;
      nx_d   = 1'b0;
      nv_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      inexact_o <= 1'b0;
      invalid_o <= 1'b0;
      undef_o   <= 1'b0;
    end else begin
      result_o  <= word_d;
      inexact_o <= nx_d;
      invalid_o <= nv_d;
      undef_o   <= undef;
    end
  end
endmodule

// File: rtl/fp_rint_chk.sv
module fp_rint_chk #(
  parameter bit HALF_EN = 1'b1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [31:0]  op_s_i,
  input logic [1:0]   fmt_i,
  input logic [2:0]   rmode_i,
  input logic         merge_i,
  input logic [111:0] dest_hi_i,
  input logic [127:0] result_o,
  input logic         inexact_o,
  input logic         invalid_o,
  input logic         undef_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (result_o == '0 && !inexact_o && !invalid_o && !undef_o); // R11
    end
  end

  AST_UNDEF_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (result_o == '0 && !inexact_o && !invalid_o)); // R1

  AST_UNDEF_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> undef_o == ($past(fmt_i) == 2'b10 || ($past(fmt_i) == 2'b11 && !HALF_EN)
                           || $past(rmode_i) == 3'b101)); // R2

  AST_EXACT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && inexact_o) |-> $past(rmode_i) == 3'b110); // R9

  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inexact_o && invalid_o)); // R4

  AST_RZ_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(fmt_i) == 2'b00 && $past(rmode_i) == 3'b011 && $past(op_s_i[30:23]) != 8'hFF)
    |-> result_o[30:0] <= $past(op_s_i[30:0])); // R6

  AST_MERGE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !undef_o && $past(merge_i) && $past(fmt_i) == 2'b11)
    |-> result_o[127:16] == $past(dest_hi_i)); // R10

  AST_ZERO_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$past(merge_i) && $past(fmt_i) == 2'b00)
    |-> result_o[127:32] == '0); // R10
endmodule

bind fp_rint_unit fp_rint_chk #(.HALF_EN(HALF_EN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_s_i(op_i[31:0]), .fmt_i(fmt_i),
  .rmode_i(rmode_i), .merge_i(merge_i), .dest_hi_i(dest_i[127:16]),
  .result_o(result_o), .inexact_o(inexact_o), .invalid_o(invalid_o), .undef_o(undef_o)
);

// File: tb/fp_rint_unit_bench.sv
`timescale 1ns/1ps
module fp_rint_unit_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [63:0]  op_i = '0;
  logic [1:0]   fmt_i = '0;
  logic [2:0]   rmode_i = '0;
  logic [1:0]   dyn_rm_i = '0;
  logic         merge_i = 1'b0;
  logic [127:0] dest_i = '0;
  logic [127:0] result_o;
  logic         inexact_o, invalid_o, undef_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  fp_rint_unit u_fp_rint_unit (
    .clk_i, .rst_ni, .op_i, .fmt_i, .rmode_i, .dyn_rm_i, .merge_i, .dest_i,
    .result_o, .inexact_o, .invalid_o, .undef_o
  );

  // integer reference: magnitudes handled as scaled integers
  function automatic void ref_round(input logic [63:0] op, input int ew, input int fw,
                                    input int rm, input bit ex,
                                    output logic [63:0] r, output bit nx, output bit nv);
    longint unsigned fmask, emax, bias, sgn, ef, fr, mag, ip, rem, hv, m2, e2;
    int ue, s;
    bit up;
    fmask = (64'd1 << fw) - 1;
    emax  = (64'd1 << ew) - 1;
    bias  = (64'd1 << (ew - 1)) - 1;
    sgn   = (op >> (ew + fw)) & 1;
    ef    = (op >> fw) & emax;
    fr    = op & fmask;
    r = op; nx = 0; nv = 0;
    if (ef == emax) begin
      if (fr != 0) begin
        r  = op | (64'd1 << (fw - 1));
        nv = ((fr >> (fw - 1)) & 1) == 0;
      end
    end else if (ef == 0 && fr == 0) begin
      r = op;
    end else begin
      ue = int'(ef) - int'(bias);
      if (ue >= fw) r = op;
      else if (ue < 0) begin
        case (rm)
          0: up = (ue == -1) && (fr != 0);
          4: up = (ue == -1);
          1: up = (sgn == 0);
          2: up = (sgn == 1);
          default: up = 0;
        endcase
        r  = (sgn << (ew + fw)) | (up ? (bias << fw) : 64'd0);
        nx = ex;
      end else begin
        s   = fw - ue;
        mag = (64'd1 << fw) | fr;
        ip  = mag >> s;
        rem = mag & ((64'd1 << s) - 1);
        hv  = 64'd1 << (s - 1);
        case (rm)
          0: up = (rem > hv) || (rem == hv && (ip & 1) == 1);
          4: up = (rem >= hv);
          1: up = (sgn == 0) && rem != 0;
          2: up = (sgn == 1) && rem != 0;
          default: up = 0;
        endcase
        ip = ip + (up ? 1 : 0);
        m2 = ip << s;
        e2 = ef;
        if ((m2 >> (fw + 1)) != 0) begin e2 = ef + 1; m2 = m2 >> 1; end
        r  = (sgn << (ew + fw)) | (e2 << fw) | (m2 & fmask);
        nx = ex && rem != 0;
      end
    end
  endfunction

  task automatic run_vec(input logic [63:0] op, input logic [1:0] fmt, input logic [2:0] rmode,
                         input logic [1:0] dyn, input bit merge, input logic [127:0] dest,
                         input string tag);
    logic [127:0] ew_word;
    logic [63:0] r;
    bit nx, nv, ud;
    int rm, ew, fw;
    op_i = op; fmt_i = fmt; rmode_i = rmode; dyn_rm_i = dyn; merge_i = merge; dest_i = dest;
    ud = (fmt == 2'b10) || (rmode == 3'b101);
    if (rmode[2] == 1'b0)  rm = int'(rmode[1:0]);
    else if (rmode == 3'b100) rm = 4;
    else rm = int'(dyn);
    case (fmt)
      2'b00: begin ew = 8;  fw = 23; end
      2'b01: begin ew = 11; fw = 52; end
      default: begin ew = 5; fw = 10; end
    endcase
    ref_round(op, ew, fw, rm, rmode == 3'b110, r, nx, nv);
    ew_word = merge ? dest : '0;
    case (fmt)
      2'b00: ew_word[31:0] = r[31:0];
      2'b01: ew_word[63:0] = r;
      2'b11: ew_word[15:0] = r[15:0];
      default: ;
    endcase
    if (ud) begin ew_word = '0; nx = 0; nv = 0; end
    @(negedge clk_i);
    n_chk++;
    if (result_o !== ew_word || inexact_o !== nx || invalid_o !== nv || undef_o !== ud) begin
      n_err++;
      $display("FAIL %s op=%h fmt=%b mode=%b: got %h nx=%b nv=%b ud=%b, exp %h nx=%b nv=%b ud=%b",
               tag, op, fmt, rmode, result_o, inexact_o, invalid_o, undef_o, ew_word, nx, nv, ud);
    end
  endtask

  function automatic string cls(input logic [63:0] op, input logic [1:0] fmt, input logic [2:0] rmode);
    int ew, fw, ue;
    longint unsigned ef, fr;
    if (fmt == 2'b10 || rmode == 3'b101) return "R1";
    case (fmt)
      2'b00: begin ew = 8;  fw = 23; end
      2'b01: begin ew = 11; fw = 52; end
      default: begin ew = 5; fw = 10; end
    endcase
    ef = (op >> fw) & ((64'd1 << ew) - 1);
    fr = op & ((64'd1 << fw) - 1);
    ue = int'(ef) - ((1 << (ew - 1)) - 1);
    if (ef == (64'd1 << ew) - 1) return (fr != 0) ? "R4" : "R3";
    if (ef == 0 && fr == 0) return "R3";
    if (ue >= fw) return "R5";
    if (ue < 0) return "R8";
    if (rmode == 3'b110) return "R9";
    if (rmode == 3'b011) return "R6";
    return "R7";
  endfunction

  localparam logic [127:0] PAT = 128'hA5A5_5A5A_C3C3_3C3C_F00F_0FF0_1234_5678;

  initial begin
    #1 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    n_chk++; // R11 reset state
    if (result_o !== '0 || inexact_o || invalid_o || undef_o) begin
      n_err++;
      $display("FAIL R11 reset: got %h %b%b%b, exp 0", result_o, inexact_o, invalid_o, undef_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R6 toward zero
    run_vec(64'h3FC00000, 2'b00, 3'b011, 2'b00, 0, PAT, "R6");
    run_vec(64'hC0600000, 2'b00, 3'b011, 2'b00, 0, PAT, "R6");
    // R7 ties
    run_vec(64'h3FC00000, 2'b00, 3'b000, 2'b00, 0, PAT, "R7");
    run_vec(64'h40200000, 2'b00, 3'b000, 2'b00, 0, PAT, "R7");
    run_vec(64'h40200000, 2'b00, 3'b100, 2'b00, 0, PAT, "R7");
    run_vec(64'h3FF8000000000000, 2'b01, 3'b001, 2'b00, 0, PAT, "R7");
    // R8 below one
    run_vec(64'h3F000000, 2'b00, 3'b000, 2'b00, 0, PAT, "R8");
    run_vec(64'h3F000000, 2'b00, 3'b100, 2'b00, 0, PAT, "R8");
    run_vec(64'hBE99999A, 2'b00, 3'b010, 2'b00, 0, PAT, "R8");
    run_vec(64'h80000001, 2'b00, 3'b001, 2'b00, 0, PAT, "R8");
    // R3 zero and infinity
    run_vec(64'h80000000, 2'b00, 3'b001, 2'b00, 0, PAT, "R3");
    run_vec(64'hFF800000, 2'b00, 3'b110, 2'b00, 0, PAT, "R3");
    // R4 NaN
    run_vec(64'h7FA00000, 2'b00, 3'b110, 2'b00, 0, PAT, "R4");
    run_vec(64'h7FC00001, 2'b00, 3'b000, 2'b00, 0, PAT, "R4");
    run_vec(64'h7D00, 2'b11, 3'b111, 2'b00, 1, PAT, "R4");
    // R5 already integral
    run_vec(64'h4B800001, 2'b00, 3'b110, 2'b01, 0, PAT, "R5");
    // R9 exact flag
    run_vec(64'h3FC00000, 2'b00, 3'b110, 2'b00, 1, PAT, "R9");
    run_vec(64'h40000000, 2'b00, 3'b110, 2'b00, 0, PAT, "R9");
    run_vec(64'h3FC00000, 2'b00, 3'b111, 2'b00, 0, PAT, "R9");
    // R2 dynamic mode and undefined mode
    run_vec(64'h3FC00000, 2'b00, 3'b111, 2'b10, 0, PAT, "R2");
    run_vec(64'h3FC00000, 2'b00, 3'b101, 2'b00, 1, PAT, "R2");
    // R1 formats
    run_vec(64'h3E00, 2'b11, 3'b001, 2'b00, 0, PAT, "R1");
    run_vec(64'h3FC00000, 2'b10, 3'b000, 2'b00, 1, PAT, "R1");
    // R10 lane insertion
    run_vec(64'h3FC00000, 2'b00, 3'b000, 2'b00, 1, PAT, "R10");
    run_vec(64'hC004000000000000, 2'b01, 3'b011, 2'b00, 1, PAT, "R10");
    run_vec(64'hFFFF_FFFF_FFFF_BE00, 2'b11, 3'b000, 2'b00, 1, PAT, "R10");
    for (int i = 0; i < 600; i++) begin
      logic [63:0] op;
      logic [1:0] fmt;
      logic [2:0] md;
      int ew, fw;
      longint unsigned bias, ef, emask;
      op  = {$urandom, $urandom};
      fmt = 2'($urandom);
      md  = 3'($urandom);
      case (fmt)
        2'b00: begin ew = 8;  fw = 23; end
        2'b01: begin ew = 11; fw = 52; end
        default: begin ew = 5; fw = 10; end
      endcase
      if ($urandom % 4 != 0) begin
        bias  = (64'd1 << (ew - 1)) - 1;
        emask = ((64'd1 << ew) - 1) << fw;
        ef    = bias - 3 + longint'($urandom % (fw + 6));
        op    = (op & ~emask) | ((ef << fw) & emask);
      end
      run_vec(op, fmt, md, 2'($urandom), 1'($urandom), {$urandom, $urandom, $urandom, $urandom},
              cls(op, fmt, md));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule